// File: doc/BRIEF.md
# Frame-Counted Audio Sample FIFO

This block sits between a register-write port and a serial audio formatter. Software writes 24-bit samples through select code 5 of a small register port. The formatter pulls them out with a read strobe. Storage is a 256-word ring. The usable part of the ring is set by the channel count (`chan_sel` holds channels minus one), so the ring is shared out in whole frames. The fill level is reported in complete frames, and software multiplies it by the channel count to get words.

A status word reports the frame level together with sticky overrun and underrun flags. A control word has two fields:
- an enable for the half-level event;
- a flush bit that clears itself.

The half-level event sets one bit of a 16-bit interrupt status register. That bit is placed by a parameter. A status bit reaches the single `irq` output only when the same bit is set in both mask registers. Status bits are cleared by writing zero to them.

The fill accounting runs as a small state machine with four states:
- EMPTY: no words held.
- PART: some words held, but fewer than the frame capacity.
- FULL: the word count has reached the frame capacity.
- FLUSH: a flush is in progress, lasting one cycle.

Its transitions are:
- EMPTY, PART and FULL move among themselves according to the count after each push or pop.
- Any state goes to FLUSH when a control write has bit 0 set.
- FLUSH always goes to EMPTY on the next cycle, unless another flush write arrives in that cycle.

Top module: `audio_frame_fifo`

## Requirements
- R1: After reset these all read 0: the control word, the status word, the interrupt status, both masks, `irq` and `rd_data`.
- R2: Frame capacity depends on the channel count: 256 frames for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8. The FIFO is full once it holds capacity × channels words.
- R3: Status bits 16:8 hold the occupied level in complete frames, which is the word count divided by the channel count with the remainder dropped.
- R4: A sample write (select 5) made while full is dropped. It sets status bit 4, which stays set until status (select 1) is written with bit 4 set.
- R5: A read strobe while empty leaves the count unchanged, and `rd_data` reads 0. It sets status bit 0, which stays set until status is written with bit 0 set.
- R6: Samples leave in the order they were written, with all 24 bits intact. `rd_data` shows the oldest sample, and a read strobe removes it.
- R7: Writing the control word (select 0) with bit 0 set makes control bit 0 read 1 for exactly one cycle. After that cycle the FIFO is empty and the level is 0.
- R8: Control bit 20 enables the half-level event. While it is set, the interrupt status bit PORT_BIT (default 0) is set when the frame level drops from above half the capacity to half or below. While it is clear, no such event is recorded.
- R9: Writing the interrupt status (select 2) clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R10: `irq` is high only when some interrupt status bit is also set in mask 0 (select 3) and in mask 1 (select 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 status, 2 interrupt status, 3 mask 0, 4 mask 1, 5 sample data |
| reg_wdata | input | 32 | Write data |
| rd_en | input | 1 | Formatter read strobe |
| chan_sel | input | 3 | Channel count minus one |
| rd_data | output | 24 | Oldest sample, or 0 when empty |
| ctrl_word | output | 32 | Bit 20 is the half-level enable; bit 0 reads 1 while a flush is in progress |
| stat_word | output | 32 | Bits 16:8 frame level, bit 4 overrun, bit 0 underrun |
| irq_status | output | 16 | Interrupt status |
| irq_mask0 | output | 16 | First mask |
| irq_mask1 | output | 16 | Second mask |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the following corner cases:

- **Capacity at odd channel counts.** At 5 channels the bench fills past 160 words. A design that took the capacity straight from the word depth would keep accepting samples, report a level above 32 frames and never raise the overrun flag.
- **Half-level crossing.** The bench steps down from 130 frames, checking that the event fires at exactly 128 and not at 129, and that it stays silent while the enable is clear. An off-by-one comparison would move or lose the event.
- **Masking and clearing.** The bench sets one mask at a time, then writes all ones and then zero to the interrupt status. A design that used OR instead of AND for the masks would raise `irq` early. A design that inverted the clear sense would wipe the bit on the all-ones write.
- **Flush bit lifetime.** The bench samples the flush bit on each of the two cycles after the flush write. A bit that never self-clears, or a flush that leaves the count behind, shows up there.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2,
        FS_FLUSH = 2'd3
    } fill_state_t;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_STAT  = 3'd1;
    localparam logic [2:0] SEL_ISTAT = 3'd2;
    localparam logic [2:0] SEL_MASK0 = 3'd3;
    localparam logic [2:0] SEL_MASK1 = 3'd4;
    localparam logic [2:0] SEL_DATA  = 3'd5;

    localparam int CTRL_FLUSH_BIT = 0;
    localparam int CTRL_HALF_BIT  = 20;
    localparam int STAT_OVR_BIT   = 4;
    localparam int STAT_UDR_BIT   = 0;

    // frames available for a given channel-count code
    function automatic int unsigned frames_for(int unsigned depth, logic [2:0] csel);
        unique case (csel)
            3'd0:       return depth;
            3'd1:       return depth / 2;
            3'd2, 3'd3: return depth / 4;
            default:    return depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DW    = 24,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else if (clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + AW'(1);
            if (pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
        end
    end

    assign rdata = mem[rd_ptr_q];

endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    chan_sel,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          flush_req,
    input  logic          ovr_clr,
    input  logic          udr_clr,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          store_clr,
    output logic          empty,
    output logic          flushing,
    output logic          at_half,
    output logic [CW-1:0] level,
    output logic          ovr,
    output logic          udr
);
    fill_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ovr_q, udr_q;
    logic [CW-1:0] cap_frames;
    logic [3:0]    chans;
    logic [CW+3:0] cap_words;
    logic          full_now, full_d;

    assign cap_frames = CW'(frames_for(DEPTH, chan_sel));
    assign chans      = {1'b0, chan_sel} + 4'd1;
    assign cap_words  = {4'd0, cap_frames} * {{CW{1'b0}}, chans};
    assign full_now   = {4'd0, cnt_q} >= cap_words;
    assign full_d     = {4'd0, cnt_d} >= cap_words;

    // output / datapath decode
    always_comb begin
        flushing  = (state_q == FS_FLUSH);
        push_ok   = push_req && !flushing && !full_now;
        pop_ok    = pop_req && !flushing && (cnt_q != '0);
        store_clr = flushing;
        empty     = (state_q == FS_EMPTY) || flushing;
        cnt_d     = flushing ? '0 : cnt_q + CW'(push_ok) - CW'(pop_ok);
    end

    // next state
    always_comb begin
        unique case (state_q)
            FS_FLUSH: state_d = FS_EMPTY;
            FS_EMPTY, FS_PART, FS_FULL:
                state_d = (cnt_d == '0) ? FS_EMPTY : (full_d ? FS_FULL : FS_PART);
        endcase
        if (flush_req) state_d = FS_FLUSH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovr_q <= 1'b0;
            udr_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (push_req && !flushing && full_now) ovr_q <= 1'b1;
            else if (ovr_clr)                      ovr_q <= 1'b0;
            if (pop_req && !flushing && cnt_q == '0) udr_q <= 1'b1;
            else if (udr_clr)                        udr_q <= 1'b0;
        end
    end

    assign level   = cnt_q / {{(CW-4){1'b0}}, chans};
    assign at_half = level <= (cap_frames >> 1);
    assign ovr     = ovr_q;
    assign udr     = udr_q;

    a_r2_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |-> ({4'd0, cnt_q} < cap_words));
    a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q && !ovr_clr |=> ovr_q);
    a_r5_udr_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_req && !flushing && cnt_q == '0 |=> cnt_q == '0 && udr_q);
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flushing && !flush_req |=> cnt_q == '0 && state_q == FS_EMPTY);

endmodule

// File: rtl/afifo_irq.sv
module afifo_irq #(
    parameter int NSRC     = 16,
    parameter int PORT_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            at_half,
    input  logic            half_en,
    input  logic            ist_we,
    input  logic            m0_we,
    input  logic            m1_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] istat,
    output logic [NSRC-1:0] mask0,
    output logic [NSRC-1:0] mask1,
    output logic            irq
);
    logic [NSRC-1:0] istat_q, m0_q, m1_q, ev_vec;
    logic            half_prev_q, half_ev;

    assign half_ev = half_en && at_half && !half_prev_q;
    assign ev_vec  = NSRC'(half_ev) << PORT_BIT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            istat_q     <= '0;
            m0_q        <= '0;
            m1_q        <= '0;
            half_prev_q <= 1'b1;
        end else begin
            half_prev_q <= at_half;
            istat_q     <= (ist_we ? (istat_q & wdata) : istat_q) | ev_vec;
            if (m0_we) m0_q <= wdata;
            if (m1_we) m1_q <= wdata;
        end
    end

    assign istat = istat_q;
    assign mask0 = m0_q;
    assign mask1 = m1_q;
    assign irq   = |(istat_q & m0_q & m1_q);

    a_r8_event_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat_q[PORT_BIT]) |-> $past(half_en));
    a_r9_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ist_we && !wdata[PORT_BIT] && !half_ev |=> !istat_q[PORT_BIT]);
    a_r10_mask0_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_q == '0) |-> !irq);
    a_r10_mask1_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_q == '0) |-> !irq);

endmodule

// File: rtl/audio_frame_fifo.sv
module audio_frame_fifo
    import afifo_pkg::*;
#(
    parameter int DW       = 24,
    parameter int DEPTH    = 256,
    parameter int NSRC     = 16,
    parameter int PORT_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    input  logic            rd_en,
    input  logic [2:0]      chan_sel,
    output logic [DW-1:0]   rd_data,
    output logic [31:0]     ctrl_word,
    output logic [31:0]     stat_word,
    output logic [NSRC-1:0] irq_status,
    output logic [NSRC-1:0] irq_mask0,
    output logic [NSRC-1:0] irq_mask1,
    output logic            irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int LW = 9;

    logic          wr_ctrl, wr_stat;
    logic          push_ok, pop_ok, store_clr, empty, flushing, at_half;
    logic          ovr, udr;
    logic [CW-1:0] level;
    logic          half_en_q;
    logic [DW-1:0] store_rdata;

    assign wr_ctrl = reg_we && (reg_addr == SEL_CTRL);
    assign wr_stat = reg_we && (reg_addr == SEL_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       half_en_q <= 1'b0;
        else if (wr_ctrl) half_en_q <= reg_wdata[CTRL_HALF_BIT];
    end

    afifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_sel  (chan_sel),
        .push_req  (reg_we && reg_addr == SEL_DATA),
        .pop_req   (rd_en),
        .flush_req (wr_ctrl && reg_wdata[CTRL_FLUSH_BIT]),
        .ovr_clr   (wr_stat && reg_wdata[STAT_OVR_BIT]),
        .udr_clr   (wr_stat && reg_wdata[STAT_UDR_BIT]),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .store_clr (store_clr),
        .empty     (empty),
        .flushing  (flushing),
        .at_half   (at_half),
        .level     (level),
        .ovr       (ovr),
        .udr       (udr)
    );

    afifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (store_clr),
        .push  (push_ok),
        .pop   (pop_ok),
        .wdata (reg_wdata[DW-1:0]),
        .rdata (store_rdata)
    );

    afifo_irq #(.NSRC(NSRC), .PORT_BIT(PORT_BIT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .at_half (at_half),
        .half_en (half_en_q),
        .ist_we  (reg_we && reg_addr == SEL_ISTAT),
        .m0_we   (reg_we && reg_addr == SEL_MASK0),
        .m1_we   (reg_we && reg_addr == SEL_MASK1),
        .wdata   (reg_wdata[NSRC-1:0]),
        .istat   (irq_status),
        .mask0   (irq_mask0),
        .mask1   (irq_mask1),
        .irq     (irq)
    );

    assign rd_data   = empty ? '0 : store_rdata;
    assign ctrl_word = {11'd0, half_en_q, 19'd0, flushing};
    assign stat_word = {15'd0, LW'(level), 3'd0, ovr, 3'd0, udr};

endmodule

// File: tb/audio_frame_fifo_bench.sv
module audio_frame_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  chan_sel = '0;
    logic [23:0] rd_data;
    logic [31:0] ctrl_word, stat_word;
    logic [15:0] irq_status, irq_mask0, irq_mask1;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    audio_frame_fifo u_audio_frame_fifo (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_en(rd_en), .chan_sel(chan_sel),
        .rd_data(rd_data), .ctrl_word(ctrl_word), .stat_word(stat_word),
        .irq_status(irq_status), .irq_mask0(irq_mask0), .irq_mask1(irq_mask1),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_n(input int n, input logic [23:0] base);
        for (int i = 0; i < n; i++) wr_reg(3'd5, {8'd0, base + 24'(i)});
    endtask

    task automatic flush();
        wr_reg(3'd0, 32'h1);
        idle(1);
    endtask

    function automatic logic [31:0] lvl(input logic [31:0] s);
        return {23'd0, s[16:8]};
    endfunction

    task automatic t_reset();
        chk("R1 ctrl", ctrl_word, 0);
        chk("R1 stat", stat_word, 0);
        chk("R1 istat", {16'd0, irq_status}, 0);
        chk("R1 masks", {irq_mask0, irq_mask1}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 rd_data", {8'd0, rd_data}, 0);
    endtask

    task automatic t_order();
        chan_sel = 3'd0;
        wr_reg(3'd5, 32'hFFA5A5A5);
        wr_reg(3'd5, 32'h00123456);
        wr_reg(3'd5, 32'h00FFFFFF);
        chk("R3 level 1ch", lvl(stat_word), 3);
        chk("R6 first", {8'd0, rd_data}, 32'h00A5A5A5);
        pop1();
        chk("R6 second", {8'd0, rd_data}, 32'h00123456);
        pop1();
        chk("R6 third", {8'd0, rd_data}, 32'h00FFFFFF);
        pop1();
        chk("R6 drained", lvl(stat_word), 0);
    endtask

    task automatic t_frames();
        chan_sel = 3'd2;
        push_n(7, 24'h100);
        chk("R3 partial frame", lvl(stat_word), 2);
        flush();
    endtask

    task automatic t_capacity();
        chan_sel = 3'd1;
        push_n(256, 24'h0);
        chk("R2 2ch level", lvl(stat_word), 128);
        chk("R2 2ch no ovr yet", {31'd0, stat_word[4]}, 0);
        wr_reg(3'd5, 32'h777);
        chk("R4 ovr set", {31'd0, stat_word[4]}, 1);
        chk("R4 level unchanged", lvl(stat_word), 128);
        idle(3);
        chk("R4 ovr sticky", {31'd0, stat_word[4]}, 1);
        wr_reg(3'd1, 32'h10);
        chk("R4 ovr cleared", {31'd0, stat_word[4]}, 0);
        flush();
        chan_sel = 3'd4;
        push_n(170, 24'h0);
        chk("R2 5ch level", lvl(stat_word), 32);
        chk("R4 5ch ovr", {31'd0, stat_word[4]}, 1);
        wr_reg(3'd1, 32'h10);
        flush();
        chan_sel = 3'd0;
    endtask

    task automatic t_flush();
        push_n(5, 24'h50);
        wr_reg(3'd0, 32'h1);
        chk("R7 flush bit high", {31'd0, ctrl_word[0]}, 1);
        idle(1);
        chk("R7 flush bit cleared", {31'd0, ctrl_word[0]}, 0);
        chk("R7 emptied", lvl(stat_word), 0);
        chk("R7 rd_data zero", {8'd0, rd_data}, 0);
    endtask

    task automatic t_underrun();
        pop1();
        chk("R5 udr set", {31'd0, stat_word[0]}, 1);
        chk("R5 level stays", lvl(stat_word), 0);
        chk("R5 rd_data zero", {8'd0, rd_data}, 0);
        wr_reg(3'd1, 32'h1);
        chk("R5 udr cleared", {31'd0, stat_word[0]}, 0);
    endtask

    task automatic t_half();
        chan_sel = 3'd0;
        wr_reg(3'd0, 32'h0);
        push_n(130, 24'h0);
        pop1(); pop1();
        idle(2);
        chk("R8 disabled no event", {16'd0, irq_status}, 0);
        wr_reg(3'd0, 32'h0010_0000);
        push_n(2, 24'h0);
        pop1();
        idle(2);
        chk("R8 no event at 129", {16'd0, irq_status}, 0);
        pop1();
        idle(2);
        chk("R8 event at 128", {16'd0, irq_status}, 1);
        chk("R10 no masks", {31'd0, irq}, 0);
        wr_reg(3'd3, 32'h1);
        chk("R10 one mask", {31'd0, irq}, 0);
        wr_reg(3'd4, 32'h1);
        chk("R10 both masks", {31'd0, irq}, 1);
        wr_reg(3'd2, 32'hFFFF);
        chk("R9 ones keep", {16'd0, irq_status}, 1);
        wr_reg(3'd2, 32'h0);
        chk("R9 zero clears", {16'd0, irq_status}, 0);
        chk("R10 irq drops", {31'd0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_frames();
        t_capacity();
        t_flush();
        t_underrun();
        t_half();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule